// File: doc/BRIEF.md
# Instruction-Byte Branch Target Cache

This block sits beside the fetch stage and shortens taken-branch redirects. When a branch is taken, fetch presents the target address on the lookup port. The block compares that address with every resident tag at once. On a match it returns, in the same cycle, the sixteen instruction bytes that begin at that target, so decode can start at once and the redirect bubble is avoided. When nothing matches it raises a miss, and fetch then reads the bytes from the instruction cache.

When the instruction cache returns the bytes for a missed target, fetch writes them in through the fill port. A fill to an address that is already resident rewrites that entry in place. Any other fill claims the entry under a round-robin pointer. A single flush input drops every entry in one cycle. It is meant for code that has been modified or for a change of address space.

Top module: `tgt_byte_cache`

## Requirements
- R1: After reset, and after any later reset, no entry is resident, so every lookup misses.
- R2: A lookup whose address equals a resident tag raises `lkp_hit` and lowers `lkp_miss` in the same cycle. `lkp_bytes` then carries the sixteen bytes stored with that tag.
- R3: A lookup with no matching resident tag raises `lkp_miss`, lowers `lkp_hit` and drives `lkp_bytes` to zero. While `lkp_valid` is low, both `lkp_hit` and `lkp_miss` are low.
- R4: A fill whose address is already resident overwrites that entry's bytes and does not use a second entry. The round-robin pointer does not move.
- R5: Bytes written by a fill can be looked up from the cycle after the clock edge that takes the fill.
- R6: Fills to new addresses go to entries 0, 1, 2 and so on in turn, wrapping after the last entry. With 16 entries, the 17th new address evicts the oldest one.
- R7: `flush_all` makes every entry non-resident at the next edge. A fill in the same cycle as a flush is dropped.
- R8: When a lookup and a fill carry the same address in one cycle, the lookup reports a miss. The fill is still written, and the address hits from the next cycle.
- R9: The whole address is compared. Addresses that differ from a resident tag only in bit 0 or only in bit 31 miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid | input | 1 | Lookup request for a taken-branch target |
| lkp_addr | input | ADDR_W (32) | Target address to look up |
| lkp_hit | output | 1 | Target resident; bytes valid this cycle |
| lkp_miss | output | 1 | Target not resident; fetch from instruction cache |
| lkp_bytes | output | LINE_BYTES*8 (128) | Instruction bytes at the target on a hit, zero otherwise |
| fill_valid | input | 1 | Install request |
| fill_addr | input | ADDR_W (32) | Target address being installed |
| fill_bytes | input | LINE_BYTES*8 (128) | Instruction bytes to install |
| flush_all | input | 1 | Drop all entries at the next edge |

## Verification
Lookup results are combinational, so `lkp_hit`, `lkp_miss` and `lkp_bytes` are due in the same cycle that the request is presented. Fills and flushes take effect at the next rising edge and show up in the lookup one cycle later. The bench drives inputs on the falling edge and samples the outputs 2 ns later. Each sample therefore reflects the state left by the previous rising edge, before the current cycle's fill or flush lands. Eviction order is checked by counting allocations at the ports. Rewrites must not move the pointer, and flushes and resets must empty the cache.

// File: rtl/tbc_pkg.sv
// Shared types for the instruction-byte branch target cache.
// Assumes: imported by every tbc_* module and by the top.
package tbc_pkg;

    // What a fill request does to the entry array in a given cycle.
    typedef enum logic [1:0] {
        FILL_IDLE     = 2'd0,
        FILL_REWRITE  = 2'd1,
        FILL_ALLOCATE = 2'd2
    } fill_kind_e;

endpackage

// File: rtl/tbc_tag_match.sv
// Parallel tag comparator: one equality check per entry, qualified by the
// entry's resident bit. Output is one bit per entry.
// Assumes: tags are full addresses; at most one resident entry per address.
module tbc_tag_match #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32
) (
    input  logic [ENTRIES-1:0]             valid_q,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q,
    input  logic [ADDR_W-1:0]              probe_addr,
    output logic [ENTRIES-1:0]             match
);

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_cmp
            // Compare one entry's tag with the probe address.
            always_comb match[gi] = valid_q[gi] && (tag_q[gi] == probe_addr);
        end
    endgenerate

endmodule

// File: rtl/tbc_victim_ptr.sv
// Round-robin replacement pointer. Steps by one on every new allocation and
// wraps from the last entry back to 0.
// Assumes: advance is asserted only for fills that allocate.
module tbc_victim_ptr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr_q
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Move to the next victim slot after each allocation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (advance)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1))); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q)); // R4

endmodule

// File: rtl/tbc_entry_store.sv
// Entry array: resident bits, tags and instruction-byte payloads. One write
// port and a one-hot-selected read port that returns zero when nothing is
// selected.
// Assumes: rd_sel is one-hot or zero; flush takes priority over a write.
module tbc_entry_store #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 128,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [ADDR_W-1:0]              wr_tag,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [ENTRIES-1:0]             rd_sel,
    output logic [ENTRIES-1:0]             valid_q,
    output logic [ENTRIES-1:0][ADDR_W-1:0] tag_q,
    output logic [DATA_W-1:0]              rd_data
);

    logic [DATA_W-1:0] data_q [ENTRIES];

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_ent
            logic hit_wr;
            // Decode the write index for this entry.
            always_comb hit_wr = wr_en && !flush && (wr_idx == IDX_W'(gi));

            // Resident bit: cleared by reset or flush, set by a write.
            always_ff @(posedge clk) begin
                if (!rst_n || flush)
                    valid_q[gi] <= 1'b0;
                else if (hit_wr)
                    valid_q[gi] <= 1'b1;
            end

            // Tag and payload: captured on a write, no reset needed.
            always_ff @(posedge clk) begin
                if (hit_wr) begin
                    tag_q[gi]  <= wr_tag;
                    data_q[gi] <= wr_data;
                end
            end
        end
    endgenerate

    // OR-combine the selected payload onto the read port.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (rd_sel[i]) rd_data = rd_data | data_q[i];
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)); // R7
    AST_WRITE_RESIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> valid_q[$past(wr_idx)]); // R5
    AST_WRITE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (tag_q[$past(wr_idx)] == $past(wr_tag))); // R5

endmodule

// File: rtl/tgt_byte_cache.sv
// Instruction-byte branch target cache, top level. Fully associative lookup
// of a taken-branch target that returns the first LINE_BYTES bytes in the
// same cycle; fill port with rewrite-in-place or round-robin allocation;
// flush of all entries.
// Assumes: lookups are combinational; fills and flushes land at the edge.
module tgt_byte_cache #(
    parameter int ENTRIES    = 16,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    localparam int DATA_W    = LINE_BYTES * 8,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_valid,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic              lkp_hit,
    output logic              lkp_miss,
    output logic [DATA_W-1:0] lkp_bytes,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_bytes,
    input  logic              flush_all
);
    import tbc_pkg::*;

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0]             lkp_match;
    logic [ENTRIES-1:0]             fill_match;
    logic [ENTRIES-1:0]             rd_sel;
    logic [IDX_W-1:0]               victim;
    logic [IDX_W-1:0]               match_idx;
    logic [IDX_W-1:0]               wr_idx;
    logic                           same_addr;
    fill_kind_e                     fill_kind;

    tbc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lkp_cmp (
        .valid_q(valid_q), .tag_q(tag_q), .probe_addr(lkp_addr), .match(lkp_match)
    );

    tbc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fill_cmp (
        .valid_q(valid_q), .tag_q(tag_q), .probe_addr(fill_addr), .match(fill_match)
    );

    tbc_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .advance(fill_kind == FILL_ALLOCATE),
        .ptr_q(victim)
    );

    tbc_entry_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush_all),
        .wr_en(fill_kind != FILL_IDLE), .wr_idx(wr_idx),
        .wr_tag(fill_addr), .wr_data(fill_bytes),
        .rd_sel(rd_sel), .valid_q(valid_q), .tag_q(tag_q), .rd_data(lkp_bytes)
    );

    // Detect a lookup racing a fill of the same target.
    always_comb same_addr = fill_valid && (fill_addr == lkp_addr);

    // Hit only for a requested, resident target not being filled right now.
    always_comb begin
        rd_sel   = (lkp_valid && !same_addr) ? lkp_match : '0;
        lkp_hit  = |rd_sel;
        lkp_miss = lkp_valid && !lkp_hit;
    end

    // Encode the one-hot fill match into an entry index.
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (fill_match[i]) match_idx = match_idx | IDX_W'(i);
    end

    // Classify the fill: dropped under flush, rewrite if resident, else allocate.
    always_comb begin
        if (!fill_valid || flush_all)
            fill_kind = FILL_IDLE;
        else if (|fill_match)
            fill_kind = FILL_REWRITE;
        else
            fill_kind = FILL_ALLOCATE;
        wr_idx = (fill_kind == FILL_REWRITE) ? match_idx : victim;
    end

    AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lkp_match) && $onehot0(fill_match)); // R4
    AST_RACE_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && fill_valid && (lkp_addr == fill_addr)) |-> (lkp_miss && !lkp_hit)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |-> (!lkp_hit && !lkp_miss)); // R3
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_miss |-> (lkp_bytes == '0)); // R3
    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_all) |=> ($countones(lkp_match) <= 1)); // R5

endmodule

// File: tb/tb_tgt_byte_cache.sv
module tb_tgt_byte_cache;
    localparam int AW = 32;
    localparam int DW = 128;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lkp_valid;
    logic [AW-1:0] lkp_addr;
    logic          lkp_hit;
    logic          lkp_miss;
    logic [DW-1:0] lkp_bytes;
    logic          fill_valid;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_bytes;
    logic          flush_all;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    tgt_byte_cache dut (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
        .lkp_hit(lkp_hit), .lkp_miss(lkp_miss), .lkp_bytes(lkp_bytes),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_bytes(fill_bytes),
        .flush_all(flush_all)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [7:0] s);
        return {4{a ^ {4{s}}}};
    endfunction

    typedef struct packed {
        logic          fv;
        logic [AW-1:0] faddr;
        logic [7:0]    fseed;
        logic          lv;
        logic [AW-1:0] laddr;
        logic          ehit;
        logic          emiss;
        logic [7:0]    eseed;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0,        8'h00, 1'b1, 32'h0000_1000, 1'b0, 1'b1, 8'h00}, // R1 empty
        '{1'b1, 32'h0000_1000, 8'h11, 1'b1, 32'h0000_1000, 1'b0, 1'b1, 8'h00}, // R8 race
        '{1'b0, 32'h0,        8'h00, 1'b1, 32'h0000_1000, 1'b1, 1'b0, 8'h11}, // R5 R2
        '{1'b1, 32'h0000_2000, 8'h22, 1'b1, 32'h0000_1001, 1'b0, 1'b1, 8'h00}, // R9 bit0
        '{1'b0, 32'h0,        8'h00, 1'b1, 32'h0000_2000, 1'b1, 1'b0, 8'h22}, // R2
        '{1'b1, 32'h0000_1000, 8'h33, 1'b1, 32'h0000_2000, 1'b1, 1'b0, 8'h22}, // R4 rewrite
        '{1'b0, 32'h0,        8'h00, 1'b1, 32'h0000_1000, 1'b1, 1'b0, 8'h33}, // R4 new bytes
        '{1'b0, 32'h0,        8'h00, 1'b0, 32'h0000_1000, 1'b0, 1'b0, 8'h00}, // R3 idle
        '{1'b0, 32'h0,        8'h00, 1'b1, 32'h8000_1000, 1'b0, 1'b1, 8'h00}  // R9 bit31
    };

    task automatic check(input string req, input logic eh, input logic em, input logic [DW-1:0] ed);
        n_checks++;
        if (lkp_hit !== eh || lkp_miss !== em || lkp_bytes !== ed) begin
            n_errors++;
            $display("FAIL %s: hit=%b miss=%b bytes=%h, expected hit=%b miss=%b bytes=%h",
                     req, lkp_hit, lkp_miss, lkp_bytes, eh, em, ed);
        end
    endtask

    // One cycle: drive on the falling edge, settle, optionally check.
    task automatic cyc(input logic fv, input logic [AW-1:0] fa, input logic [7:0] fs,
                       input logic fl, input logic lv, input logic [AW-1:0] la);
        @(negedge clk);
        fill_valid = fv; fill_addr = fa; fill_bytes = pat(fa, fs);
        flush_all = fl; lkp_valid = lv; lkp_addr = la;
        #2;
    endtask

    task automatic probe(input string req, input logic [AW-1:0] a, input logic eh, input logic [7:0] s);
        cyc(1'b0, '0, 8'h00, 1'b0, 1'b1, a);
        check(req, eh, !eh, eh ? pat(a, s) : '0);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lkp_valid = 1'b0; lkp_addr = '0;
        fill_valid = 1'b0; fill_addr = '0; fill_bytes = '0; flush_all = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        check("R1 reset outputs", 1'b0, 1'b0, '0);
        rst_n = 1'b1;

        // Table-driven sequence.
        for (int k = 0; k < NV; k++) begin
            cyc(VECS[k].fv, VECS[k].faddr, VECS[k].fseed, 1'b0, VECS[k].lv, VECS[k].laddr);
            check($sformatf("vector %0d", k), VECS[k].ehit, VECS[k].emiss,
                  VECS[k].ehit ? pat(VECS[k].laddr, VECS[k].eseed) : '0);
        end

        // Entries 0,1 hold 0x1000,0x2000; fill 14 new addresses into 2..15.
        for (int i = 0; i < 14; i++)
            cyc(1'b1, 32'h3000 + 32'(i) * 32'h10, 8'(i), 1'b0, 1'b0, '0);
        probe("R4 pointer held on rewrite", 32'h1000, 1'b1, 8'h33);
        probe("R6 all sixteen resident", 32'h2000, 1'b1, 8'h22);
        probe("R6 last allocation", 32'h30D0, 1'b1, 8'd13);

        // 17th new address evicts entry 0, then entry 1.
        cyc(1'b1, 32'h4000, 8'h44, 1'b0, 1'b0, '0);
        probe("R6 oldest evicted", 32'h1000, 1'b0, 8'h00);
        probe("R6 second kept", 32'h2000, 1'b1, 8'h22);
        probe("R6 new resident", 32'h4000, 1'b1, 8'h44);
        cyc(1'b1, 32'h4100, 8'h41, 1'b0, 1'b0, '0);
        probe("R6 wrap continues", 32'h2000, 1'b0, 8'h00);
        probe("R6 first allocation kept", 32'h3000, 1'b1, 8'd0);

        // Flush with a simultaneous fill.
        cyc(1'b1, 32'h5000, 8'h55, 1'b1, 1'b0, '0);
        probe("R7 fill dropped by flush", 32'h5000, 1'b0, 8'h00);
        probe("R7 flushed entry", 32'h4000, 1'b0, 8'h00);
        probe("R7 flushed entry", 32'h3000, 1'b0, 8'h00);
        cyc(1'b1, 32'h5000, 8'h56, 1'b0, 1'b0, '0);
        probe("R5 fill after flush", 32'h5000, 1'b1, 8'h56);

        // Reset in mid-run empties the cache.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        probe("R1 reset empties", 32'h5000, 1'b0, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule